// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a small 32-bit processor core that executes one instruction at a time, splitting each instruction into a short series of clocked steps. The steps are fetch, decode with register read, execute, memory and write-back. Each instruction class walks a fixed subset of those steps, so a simple instruction retires in fewer cycles than a load. The supported classes are register-to-register arithmetic and logic, word load, word store, branch-if-equal and an absolute jump.

Instructions and data share one word-organised memory inside the core. A preload write port fills this memory while the core is held in reset. The core also holds its own register file, whose first register is wired to zero. The core runs from address 0 once reset is released. Each time an instruction retires, a one-cycle done strobe is raised, and the register-file write and memory write of that instruction are visible on observation ports during that same cycle.

Top module: `mc_core`

## Requirements
- R1: While reset is asserted, `pc_o` is 0 and `done_o` is low. After release, which is synchronised inside the core, execution begins with a fetch at address 0.
- R2: Fetch loads the instruction register from memory at the PC and adds 4 to the PC. Memory is word-indexed by address bits [ADDR_W+1:2]. The two low bits are ignored and higher bits wrap.
- R3: Opcode 0x00 (bits [31:26]) is a register operation on the operands indexed by bits [25:21] and [20:16]. The function field bits [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than. Any other function value gives 0. The result goes to the register indexed by bits [15:11], and the instruction takes 4 cycles.
- R4: Opcode 0x23 loads the word at (register[25:21] + sign-extended bits [15:0]) into the register indexed by bits [20:16]. It takes 5 cycles.
- R5: Opcode 0x2B stores register[20:16] at that same computed address. It takes 4 cycles. The write shows on the dmem ports in the done cycle, with the full 32-bit address.
- R6: Opcode 0x04 compares the two operands. When they are equal, PC becomes the target computed in decode: the incremented PC plus the sign-extended bits [15:0] shifted left by 2. It takes 3 cycles, and a branch that is not taken leaves the PC alone.
- R7: Opcode 0x02 sets PC to the incremented PC's bits [31:28] followed by bits [25:0] and two zero bits. It takes 3 cycles.
- R8: Register 0 always reads as zero. A write aimed at it leaves `rf_we_o` low.
- R9: Any other opcode spends 2 cycles (fetch, decode) and returns to fetch. It raises no done and performs no write, and its only effect is the PC increment.
- R10: `done_o` is high for exactly one cycle, the last step of each instruction. `rf_we_o` and `dmem_we_o` are only ever high in such a cycle.
- R11: A preload write (`boot_we`) stores `boot_data` at word index `boot_addr`, and the core later fetches or loads that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_we | input | 1 | Preload write enable |
| boot_addr | input | ADDR_W | Preload word index |
| boot_data | input | 32 | Preload word |
| pc_o | output | 32 | Program counter |
| done_o | output | 1 | Instruction retired this cycle |
| rf_we_o | output | 1 | Register write this cycle |
| rf_waddr_o | output | 5 | Register written |
| rf_wdata_o | output | 32 | Value written to register |
| dmem_we_o | output | 1 | Store to memory this cycle |
| dmem_addr_o | output | 32 | Store byte address |
| dmem_wdata_o | output | 32 | Store data |

## Verification
The assertions assume that `boot_we` is used only while the core is held in reset, so no preload write can race a fetch or a store. The stimulus keeps to this by writing every memory word before releasing reset and never touching the port afterwards. The properties also assume that the default of 32 registers is kept, which matches the 5-bit register fields. Programs are random mixes of every class, including unknown opcodes and code that may overwrite itself, and a directed prefix exercises the zero register, branches taken and not taken, signed compare and misaligned addresses.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam logic [5:0] OP_RR    = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB
  } step_t;

  typedef enum logic [2:0] {
    CL_RR, CL_LOAD, CL_STORE, CL_BEQ, CL_JUMP, CL_BAD
  } iclass_t;

  typedef struct packed {
    logic ir_en;
    logic pc_inc;
    logic opnd_en;
    logic tgt_en;
    logic alu_en;
    logic mdr_en;
    logic mem_we;
    logic rf_we;
    logic pc_br;
    logic pc_jmp;
    logic data_sel;
    logic done;
  } ctl_t;

  function automatic iclass_t classify(input logic [5:0] op);
    case (op)
      OP_RR:    return CL_RR;
      OP_LOAD:  return CL_LOAD;
      OP_STORE: return CL_STORE;
      OP_BEQ:   return CL_BEQ;
      OP_JUMP:  return CL_JUMP;
      default:  return CL_BAD;
    endcase
  endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] raddr_a,
  input  logic [RIDX_W-1:0] raddr_b,
  output logic [W-1:0]      rdata_a,
  output logic [W-1:0]      rdata_b,
  input  logic              we,
  input  logic [RIDX_W-1:0] waddr,
  input  logic [W-1:0]      wdata
);

  logic [W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic wr_en;
    assign wr_en = we && (waddr == RIDX_W'(g)) && (g != 0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_en) begin
        regs_q[g] <= wdata;
      end
    end
  end

  always_comb begin
    rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
    rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];
  end

endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
  parameter int WORDS = 128,
  parameter int W     = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [5:0]   fn,
  output logic [W-1:0] y
);

  always_comb begin
    case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  iclass_t icls,
  output step_t   state_q,
  output ctl_t    ctl
);

  step_t state_d;

  always_comb begin
    state_d = state_q;
    ctl     = '0;
    case (state_q)
      ST_FETCH: begin
        ctl.ir_en  = 1'b1;
        ctl.pc_inc = 1'b1;
        state_d    = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.opnd_en = 1'b1;
        ctl.tgt_en  = 1'b1;
        state_d     = (icls == CL_BAD) ? ST_FETCH : ST_EXEC;
      end
      ST_EXEC: begin
        case (icls)
          CL_RR: begin
            ctl.alu_en = 1'b1;
            state_d    = ST_WB;
          end
          CL_LOAD, CL_STORE: begin
            ctl.alu_en = 1'b1;
            state_d    = ST_MEM;
          end
          CL_BEQ: begin
            ctl.pc_br = 1'b1;
            ctl.done  = 1'b1;
            state_d   = ST_FETCH;
          end
          CL_JUMP: begin
            ctl.pc_jmp = 1'b1;
            ctl.done   = 1'b1;
            state_d    = ST_FETCH;
          end
          default: state_d = ST_FETCH;
        endcase
      end
      ST_MEM: begin
        ctl.data_sel = 1'b1;
        if (icls == CL_LOAD) begin
          ctl.mdr_en = 1'b1;
          state_d    = ST_WB;
        end else begin
          ctl.mem_we = (icls == CL_STORE);
          ctl.done   = (icls == CL_STORE);
          state_d    = ST_FETCH;
        end
      end
      ST_WB: begin
        ctl.rf_we = 1'b1;
        ctl.done  = 1'b1;
        state_d   = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int MEM_WORDS = 128,
  parameter int NREG      = 32,
  localparam int ADDR_W   = $clog2(MEM_WORDS),
  localparam int RIDX_W   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_we,
  input  logic [ADDR_W-1:0] boot_addr,
  input  logic [31:0]       boot_data,
  output logic [31:0]       pc_o,
  output logic              done_o,
  output logic              rf_we_o,
  output logic [4:0]        rf_waddr_o,
  output logic [31:0]       rf_wdata_o,
  output logic              dmem_we_o,
  output logic [31:0]       dmem_addr_o,
  output logic [31:0]       dmem_wdata_o
);

  // reset: asserted at once, released after two clock edges
  logic rst_s1_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_core_n <= rst_s1_q;
    end
  end

  // architectural and step registers
  logic [31:0] pc_q, ir_q, a_q, b_q, tgt_q, alu_q, mdr_q;
  logic [31:0] pc_d, a_d, b_d, tgt_d, alu_d, mem_rdata, alu_res;
  logic        pc_en, a_eq;
  step_t       state_q;
  iclass_t     icls;
  ctl_t        ctl;

  logic [31:0] imm_sx;
  logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
  logic [31:0] wr_data;

  assign icls   = classify(ir_q[31:26]);
  assign imm_sx = {{16{ir_q[15]}}, ir_q[15:0]};
  assign rs_idx = ir_q[21 +: RIDX_W];
  assign rt_idx = ir_q[16 +: RIDX_W];
  assign rd_idx = ir_q[11 +: RIDX_W];
  assign a_eq   = (a_q == b_q);

  mc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .icls    (icls),
    .state_q (state_q),
    .ctl     (ctl)
  );

  // unified memory: preload port has priority over core stores
  logic [ADDR_W-1:0] mem_raddr, mem_waddr;
  logic [31:0]       mem_wdata;
  logic              mem_we;

  assign mem_raddr = ctl.data_sel ? alu_q[ADDR_W+1:2] : pc_q[ADDR_W+1:2];
  assign mem_we    = boot_we | ctl.mem_we;
  assign mem_waddr = boot_we ? boot_addr : alu_q[ADDR_W+1:2];
  assign mem_wdata = boot_we ? boot_data : b_q;

  mc_mem #(.WORDS(MEM_WORDS), .W(32)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  // register file
  assign wr_idx  = (icls == CL_LOAD) ? rt_idx : rd_idx;
  assign wr_data = (icls == CL_LOAD) ? mdr_q : alu_q;

  mc_regfile #(.NREG(NREG), .W(32)) u_rf (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .raddr_a (rs_idx),
    .raddr_b (rt_idx),
    .rdata_a (a_d),
    .rdata_b (b_d),
    .we      (ctl.rf_we),
    .waddr   (wr_idx),
    .wdata   (wr_data)
  );

  mc_alu #(.W(32)) u_alu (
    .a  (a_q),
    .b  (b_q),
    .fn (ir_q[5:0]),
    .y  (alu_res)
  );

  // next-state for datapath registers
  always_comb begin
    pc_d  = pc_q;
    pc_en = 1'b0;
    if (ctl.pc_inc) begin
      pc_d  = pc_q + 32'd4;
      pc_en = 1'b1;
    end else if (ctl.pc_br && a_eq) begin
      pc_d  = tgt_q;
      pc_en = 1'b1;
    end else if (ctl.pc_jmp) begin
      pc_d  = {pc_q[31:28], ir_q[25:0], 2'b00};
      pc_en = 1'b1;
    end
  end

  assign tgt_d = pc_q + {imm_sx[29:0], 2'b00};
  assign alu_d = (icls == CL_RR) ? alu_res : (a_q + imm_sx);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      tgt_q <= '0;
      alu_q <= '0;
      mdr_q <= '0;
    end else begin
      if (pc_en)       pc_q  <= pc_d;
      if (ctl.ir_en)   ir_q  <= mem_rdata;
      if (ctl.opnd_en) a_q   <= a_d;
      if (ctl.opnd_en) b_q   <= b_d;
      if (ctl.tgt_en)  tgt_q <= tgt_d;
      if (ctl.alu_en)  alu_q <= alu_d;
      if (ctl.mdr_en)  mdr_q <= mem_rdata;
    end
  end

  // observation ports
  assign pc_o         = pc_q;
  assign done_o       = ctl.done;
  assign rf_we_o      = ctl.rf_we && (wr_idx != '0);
  assign rf_waddr_o   = 5'(wr_idx);
  assign rf_wdata_o   = wr_data;
  assign dmem_we_o    = ctl.mem_we;
  assign dmem_addr_o  = alu_q;
  assign dmem_wdata_o = b_q;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input step_t       state,
  input iclass_t     icls,
  input logic [31:0] pc,
  input logic        a_eq,
  input logic        done,
  input logic        rf_we,
  input logic [4:0]  rf_waddr,
  input logic        dmem_we
);

  a_r2_fetch_adds_four: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |=> (pc == $past(pc) + 32'd4));

  a_r1_decode_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE) |-> ($past(state) == ST_FETCH));

  a_r5_store_retires: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (done && state == ST_MEM && icls == CL_STORE));

  a_r6_untaken_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && icls == CL_BEQ && !a_eq) |=> $stable(pc));

  a_r8_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != 5'd0));

  a_r9_bad_back_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE && icls == CL_BAD) |=> (state == ST_FETCH));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_writes_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || dmem_we) |-> done);

endmodule

bind mc_core mc_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .state    (state_q),
  .icls     (icls),
  .pc       (pc_q),
  .a_eq     (a_eq),
  .done     (done_o),
  .rf_we    (rf_we_o),
  .rf_waddr (rf_waddr_o),
  .dmem_we  (dmem_we_o)
);

// File: tb/mc_core_test.sv
module mc_core_test;

  localparam int MW = 128;
  localparam int AW = $clog2(MW);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          boot_we;
  logic [AW-1:0] boot_addr;
  logic [31:0]   boot_data;
  logic [31:0]   pc_o, rf_wdata_o, dmem_addr_o, dmem_wdata_o;
  logic [4:0]    rf_waddr_o;
  logic          done_o, rf_we_o, dmem_we_o;

  always #10 clk = ~clk;

  mc_core #(.MEM_WORDS(MW)) uut (
    .clk(clk), .rst_n(rst_n), .boot_we(boot_we), .boot_addr(boot_addr),
    .boot_data(boot_data), .pc_o(pc_o), .done_o(done_o), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .dmem_we_o(dmem_we_o),
    .dmem_addr_o(dmem_addr_o), .dmem_wdata_o(dmem_wdata_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference state
  bit [31:0] m_mem [MW];
  bit [31:0] m_reg [32];
  bit [31:0] m_pc;

  function automatic int widx(input bit [31:0] a);
    return int'(a[AW+1:2]);
  endfunction

  function automatic bit is_valid(input bit [5:0] op);
    return op == 6'h00 || op == 6'h23 || op == 6'h2B || op == 6'h04 || op == 6'h02;
  endfunction

  function automatic bit [31:0] enc_r(input int rs, input int rt, input int rd,
                                      input bit [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic bit [31:0] enc_i(input bit [5:0] op, input int rs,
                                      input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic bit [31:0] alu_ref(input bit [31:0] a, input bit [31:0] b,
                                        input bit [5:0] fn);
    case (fn)
      6'h20:   return a + b;
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      6'h2A:   return {31'd0, $signed(a) < $signed(b)};
      default: return 32'd0;
    endcase
  endfunction

  // expected outcome of one retired instruction
  bit        e_rfwe, e_dwe, e_r0dst;
  bit [4:0]  e_rfa;
  bit [31:0] e_rfd, e_da, e_dd;
  int        e_cyc, e_skip;
  string     e_tag;

  task automatic model_step();
    bit [31:0] ir, a, b, sx, addr;
    int rs, rt, rd;
    e_skip = 0;
    while (!is_valid(m_mem[widx(m_pc)][31:26]) && e_skip < 512) begin
      m_pc += 4;
      e_skip++;
    end
    ir = m_mem[widx(m_pc)];
    m_pc += 4;
    rs = int'(ir[25:21]); rt = int'(ir[20:16]); rd = int'(ir[15:11]);
    a = m_reg[rs]; b = m_reg[rt];
    sx = {{16{ir[15]}}, ir[15:0]};
    e_rfwe = 0; e_dwe = 0; e_r0dst = 0; e_rfa = 0; e_rfd = 0; e_da = 0; e_dd = 0;
    case (ir[31:26])
      6'h00: begin
        e_tag = "R3"; e_cyc = 4;
        e_rfd = alu_ref(a, b, ir[5:0]); e_rfa = 5'(rd);
        e_rfwe = (rd != 0); e_r0dst = (rd == 0);
        if (rd != 0) m_reg[rd] = e_rfd;
      end
      6'h23: begin
        e_tag = "R4"; e_cyc = 5;
        addr = a + sx;
        e_rfd = m_mem[widx(addr)]; e_rfa = 5'(rt);
        e_rfwe = (rt != 0); e_r0dst = (rt == 0);
        if (rt != 0) m_reg[rt] = e_rfd;
      end
      6'h2B: begin
        e_tag = "R5"; e_cyc = 4;
        addr = a + sx;
        e_dwe = 1; e_da = addr; e_dd = b;
        m_mem[widx(addr)] = b;
      end
      6'h04: begin
        e_tag = "R6"; e_cyc = 3;
        if (a == b) m_pc = m_pc + {sx[29:0], 2'b00};
      end
      default: begin
        e_tag = "R7"; e_cyc = 3;
        m_pc = {m_pc[31:28], ir[25:0], 2'b00};
      end
    endcase
  endtask

  task automatic build_program();
    bit [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    void'($urandom(32'd20240611));
    for (int i = 0; i < MW; i++) m_mem[i] = $urandom();
    m_mem[64] = 32'h8000_0005;
    // directed prefix
    m_mem[0]  = enc_i(6'h23, 0, 1, 256);          // r1 = mem[64]
    m_mem[1]  = enc_i(6'h23, 0, 2, 256);          // r2 = mem[64]
    m_mem[2]  = enc_i(6'h04, 1, 2, 1);            // taken, skips word 3
    m_mem[3]  = {6'h02, 26'd0};
    m_mem[4]  = enc_r(1, 2, 0, 6'h20);            // write to r0 dropped
    m_mem[5]  = enc_i(6'h2B, 0, 0, 260);          // store r0 -> 0
    m_mem[6]  = {6'h3F, 26'h155_5555};            // unknown opcode
    m_mem[7]  = enc_i(6'h04, 1, 0, 5);            // not taken
    m_mem[8]  = enc_r(0, 1, 3, 6'h2A);            // signed slt: 0 < neg = 0
    m_mem[9]  = enc_r(0, 1, 4, 6'h22);
    m_mem[10] = enc_i(6'h23, 0, 5, 258);          // misaligned -> word 64
    m_mem[11] = {6'h02, 26'd12};
    for (int i = 12; i < 64; i++) begin
      int r, rs, rt, rd, imm;
      bit [5:0] op;
      r  = int'($urandom_range(0, 99));
      rs = int'($urandom_range(0, 7));
      rt = int'($urandom_range(0, 7));
      rd = int'($urandom_range(0, 7));
      if (rs == 0) imm = 256 + 4 * int'($urandom_range(0, 63));
      else         imm = int'($urandom_range(0, 40)) - 20;
      if (r < 40) begin
        if (r < 4) m_mem[i] = enc_r(rs, rt, rd, 6'($urandom()));
        else       m_mem[i] = enc_r(rs, rt, rd, fns[$urandom_range(0, 4)]);
      end else if (r < 60) m_mem[i] = enc_i(6'h23, rs, rt, imm);
      else if (r < 75)     m_mem[i] = enc_i(6'h2B, rs, rt, imm);
      else if (r < 85)     m_mem[i] = enc_i(6'h04, rs, rt, int'($urandom_range(0, 12)) - 6);
      else if (r < 90)     m_mem[i] = {6'h02, 26'($urandom_range(12, 63))};
      else begin
        op = 6'($urandom());
        while (is_valid(op)) op = 6'($urandom());
        m_mem[i] = {op, 26'($urandom())};
      end
    end
  endtask

  initial begin
    int since, idle, total, n_done;
    bit first, pend;
    bit [31:0] pend_pc;
    string pend_tag;
    rst_n = 1'b0; boot_we = 1'b0; boot_addr = '0; boot_data = '0;
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;
    build_program();
    // preload while reset is held
    for (int i = 0; i < MW; i++) begin
      @(negedge clk);
      boot_we = 1'b1; boot_addr = AW'(i); boot_data = m_mem[i];
    end
    @(negedge clk);
    boot_we = 1'b0;
    chk(pc_o == 32'd0, "R1 reset pc", pc_o, 32'd0);
    chk(done_o == 1'b0, "R1 reset done", 32'(done_o), 32'd0);
    rst_n = 1'b1;
    since = 0; idle = 0; total = 0; n_done = 0; first = 1; pend = 0;
    pend_tag = "";
    while (n_done < 400) begin
      @(negedge clk);
      since++; total++;
      if (pend) begin
        chk(pc_o == pend_pc, pend_tag, pc_o, pend_pc);
        pend = 0;
      end
      if (done_o) begin
        idle = 0;
        model_step();
        chk(rf_we_o == e_rfwe, e_r0dst ? "R8 zero-register write" : {e_tag, " rf_we"},
            32'(rf_we_o), 32'(e_rfwe));
        if (e_rfwe) begin
          chk(rf_waddr_o == e_rfa, {e_tag, " dest"}, 32'(rf_waddr_o), 32'(e_rfa));
          chk(rf_wdata_o == e_rfd, first ? "R11 preloaded data" : {e_tag, " value"},
              rf_wdata_o, e_rfd);
        end
        chk(dmem_we_o == e_dwe, {e_tag, " dmem_we"}, 32'(dmem_we_o), 32'(e_dwe));
        if (e_dwe) begin
          chk(dmem_addr_o == e_da, "R5 address", dmem_addr_o, e_da);
          chk(dmem_wdata_o == e_dd, "R5 data (R8 when source is r0)", dmem_wdata_o, e_dd);
        end
        if (!first)
          chk(since == e_cyc + 2 * e_skip, e_skip > 0 ? "R9 skip cycles" : {e_tag, " cycles"},
              32'(since), 32'(e_cyc + 2 * e_skip));
        pend_tag = (e_tag == "R6" || e_tag == "R7") ? {e_tag, " next pc"} : "R2 next pc";
        pend = 1; pend_pc = m_pc;
        since = 0; first = 0; n_done++;
      end else begin
        idle++;
        chk(!rf_we_o && !dmem_we_o, "R10 write outside done",
            {30'd0, rf_we_o, dmem_we_o}, 32'd0);
      end
      if (idle > 3000 || total > 150000) begin
        chk(1'b0, "watchdog expired", 32'(total), 32'd0);
        break;
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule